// File: doc/BRIEF.md
# Two-Wire Expander Read Controller

This block is the host side of a two-pin link to a 12-bit parallel-in, serial-out input expander. It owns the serial clock line. It shares one bidirectional line with the expander: the host uses that line to start a read, and the expander uses it to return data. After system reset the controller leaves the shared line released and issues a fixed burst of clock falling edges. This burst puts the expander into its listening state, whatever state it powered up in.

Once that reset burst is over, a one-cycle start request begins a read. With the clock high, the controller pulls the line low for one phase, which makes the expander latch its parallel inputs. The controller then releases the line and toggles the clock. It captures one bit just before each of the second through thirteenth falling edges. The captured word appears with a one-cycle valid strobe, and the clock is left high with the line released until the next request.

Every high phase, low phase and start pulse lasts `PHASE` system cycles, the smallest count that covers 250 ns at the system clock frequency given by `CLK_MHZ`.

Top module: `exp_read_ctrl`

## Requirements
- R1: After reset the controller holds `line_oe_o` low, holds `busy_o` high, and produces exactly `RST_EDGES` (13) falling edges on `sclk_o`. It then leaves `sclk_o` high and lowers `busy_o`, without ever pulsing `valid_o`.
- R2: A start request while `busy_o` is high, including during the reset burst, is ignored: it adds no clock edges, no line drive and no extra valid pulse. `line_oe_o` is high only while `busy_o` is high.
- R3: A start request while idle raises `busy_o` and `line_oe_o` on the next cycle, with `line_o` low and `sclk_o` high. The line is driven for `PHASE` cycles (at least 250 ns).
- R4: `line_oe_o` is never high while `sclk_o` is low, and it is low before the first clock falling edge of a read. The host never drives the line against the expander.
- R5: Every high and low level of `sclk_o` lasts at least `PHASE` system cycles (at least 250 ns each, so the clock period is at least 500 ns).
- R6: Each bit is sampled at the end of a high phase, just before falling edges 2 to 13. The bit launched by falling edge k lands in `data_o[k-1]`, so the first bit received (D0) is `data_o[0]`.
- R7: Each read issues exactly `NBITS+1` = 13 clock falling edges. After the last one the clock returns high, the line stays released and the expander is back in its listening state.
- R8: `valid_o` is high for exactly one cycle per read. `data_o` holds the assembled word until the next read completes.
- R9: `busy_o` falls in the same cycle that `valid_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Read request, honoured only while idle |
| busy_o | output | 1 | High during the reset burst and during a read |
| data_o | output | NBITS | Last assembled word, D0 in bit 0 |
| valid_o | output | 1 | One-cycle strobe when `data_o` is updated |
| sclk_o | output | 1 | Serial clock to the expander |
| line_i | input | 1 | Level sensed on the shared line |
| line_o | output | 1 | Value driven on the shared line (always low) |
| line_oe_o | output | 1 | Output enable for the shared line |

## Verification
The in-module assertions check the following on every cycle:
- the line is never enabled while the clock is low or while the block is idle;
- the line is released at every clock fall;
- no clock level is shorter than `PHASE`;
- `valid_o` is a single-cycle strobe that coincides with `busy_o` dropping.

Only the bench scenarios can show the rest, using a behavioural expander model that answers 380 ns after each fall:
- the edge counts of the reset burst and of each read;
- the bit order and the sampling instant;
- that requests during the burst or during a read are dropped;
- that the word is held afterwards.

// File: rtl/exp_read_ctrl.sv
module exp_read_ctrl #(
  parameter int CLK_MHZ   = 250,
  parameter int NBITS     = 12,
  parameter int RST_EDGES = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             busy_o,
  output logic [NBITS-1:0] data_o,
  output logic             valid_o,
  output logic             sclk_o,
  input  logic             line_i,
  output logic             line_o,
  output logic             line_oe_o
);
  localparam int PHASE = (250 * CLK_MHZ + 999) / 1000;
  localparam int PW    = $clog2(PHASE + 1);
  localparam int ETOP  = (RST_EDGES > NBITS + 1) ? RST_EDGES : NBITS + 1;
  localparam int EW    = $clog2(ETOP + 1);

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_START, S_SHIFT} st_t;

  st_t              st;
  logic [PW-1:0]    pcnt;
  logic [EW-1:0]    ecnt;
  logic [NBITS-1:0] shreg;
  logic [1:0]       lsync;

  wire run  = (st != S_IDLE);
  wire tick = (pcnt == PW'(PHASE - 1));

  assign busy_o = run;
  assign line_o = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_INIT;
      pcnt      <= '0;
      ecnt      <= '0;
      sclk_o    <= 1'b1;
      line_oe_o <= 1'b0;
      shreg     <= '0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      lsync     <= 2'b11;
    end else begin
      valid_o <= 1'b0;
      lsync   <= {lsync[0], line_i};
      pcnt    <= (!run || tick) ? '0 : pcnt + 1'b1;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            st        <= S_START;
            line_oe_o <= 1'b1;
          end
        end
        S_START: begin
          if (tick) begin
            line_oe_o <= 1'b0;
            ecnt      <= '0;
            st        <= S_SHIFT;
          end
        end
        default: begin
          if (tick) begin
            if (sclk_o) begin
              sclk_o <= 1'b0;
              ecnt   <= ecnt + 1'b1;
              if (st == S_SHIFT && ecnt != '0)
                shreg <= {lsync[1], shreg[NBITS-1:1]};
            end else begin
              sclk_o <= 1'b1;
              if (st == S_INIT && ecnt == EW'(RST_EDGES))
                st <= S_IDLE;
              if (st == S_SHIFT && ecnt == EW'(NBITS + 1)) begin
                st      <= S_IDLE;
                valid_o <= 1'b1;
                data_o  <= shreg;
              end
            end
          end
        end
      endcase
    end
  end

  logic [PW-1:0] hold_c;
  logic          sclk_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_c <= '0;
      sclk_d <= 1'b1;
    end else begin
      sclk_d <= sclk_o;
      if (sclk_o != sclk_d)      hold_c <= PW'(1);
      else if (hold_c != PW'(PHASE)) hold_c <= hold_c + 1'b1;
    end
  end

  // R4
  oe_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
    line_oe_o |-> sclk_o);

  // R4
  fall_released_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> !line_oe_o);

  // R5
  phase_min_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_o != sclk_d) |-> (hold_c >= PW'(PHASE)));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R9
  busy_valid_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (!busy_o && $past(busy_o)));

  // R2
  oe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    line_oe_o |-> busy_o);
endmodule

// File: tb/exp_read_ctrl_tb.sv
`timescale 1ns/1ps
module exp_read_ctrl_tb_top;
  localparam int NB = 12;
  localparam int NV = 6;
  localparam logic [NB-1:0] VEC [NV] = '{12'h000, 12'hFFF, 12'hA5C,
                                         12'h001, 12'h800, 12'h3C6};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start;
  logic busy, valid, sclk, dut_o, dut_oe;
  logic [NB-1:0] data;

  logic s_oe = 1'b1, s_o = 1'b0, s_in = 1'b0;
  int   s_cnt = 0;
  logic [NB-1:0] pins = '0, latched = '0;

  wire line_w = (dut_oe === 1'b1) ? dut_o : (s_oe ? s_o : 1'b1);

  exp_read_ctrl dut_i (
    .clk(clk), .rst(rst), .start_i(start), .busy_o(busy), .data_o(data),
    .valid_o(valid), .sclk_o(sclk), .line_i(line_w), .line_o(dut_o),
    .line_oe_o(dut_oe));

  // expander model
  always @(negedge sclk) begin
    if (!s_in) begin
      s_cnt = s_cnt + 1;
      if (s_cnt <= NB) begin
        #380;
        s_o = latched[s_cnt-1];
      end else begin
        s_oe = 1'b0;
        s_in = 1'b1;
      end
    end
  end
  always @(negedge line_w) begin
    if (sclk === 1'b1 && s_in) begin
      latched = pins;
      s_in = 1'b0; s_oe = 1'b1; s_o = 1'b0; s_cnt = 0;
    end
  end

  // monitors
  int nchk = 0, nerr = 0;
  int falls = 0, vcount = 0, dbl = 0, coll = 0, oe_low_fall = 0, oe_cnt = 0;
  realtime t_clk = 0, t_oe = 0, minw = 1.0e9, oew = 1.0e9;
  logic vprev = 1'b0;

  always @(negedge sclk) begin
    if (rst === 1'b0) begin
      falls++;
      if (dut_oe === 1'b1) oe_low_fall++;
    end
  end
  always @(sclk) begin
    if (rst === 1'b0) begin
      if ($realtime - t_clk < minw) minw = $realtime - t_clk;
      t_clk = $realtime;
    end
  end
  always @(posedge dut_oe) t_oe = $realtime;
  always @(negedge dut_oe) if ($realtime - t_oe < oew) oew = $realtime - t_oe;
  always @(posedge clk) begin
    if (rst === 1'b0) begin
      if (valid && vprev) dbl++;
      if (valid) vcount++;
      if (dut_oe === 1'b1 && s_oe && dut_o != s_o) coll++;
      if (dut_oe === 1'b1) oe_cnt++;
    end
    vprev <= valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic read_word(input logic [NB-1:0] v);
    pins = v; falls = 0; vcount = 0; minw = 1.0e9; oew = 1.0e9;
    pulse_start();
    chk(busy === 1'b1 && dut_oe === 1'b1 && dut_o === 1'b0 && sclk === 1'b1,
        "R3 start drive", {busy, dut_oe, dut_o, sclk}, 4'b1101);
    @(posedge valid);
    @(negedge clk);
    chk(data === v, "R6 word", data, v);
    chk(busy === 1'b0, "R9 busy with valid", busy, 0);
    chk(falls == NB + 1, "R7 fall count", falls, NB + 1);
    repeat (20) @(negedge clk);
    chk(vcount == 1 && dbl == 0, "R8 single valid", vcount, 1);
    chk(data === v, "R8 data held", data, v);
    chk(sclk === 1'b1 && s_in && dut_oe === 1'b0, "R7 idle after read",
        {sclk, s_in, dut_oe}, 3'b110);
    chk(minw >= 250.0, "R5 phase width", int'(minw), 250);
    chk(oew >= 250.0, "R3 start pulse width", int'(oew), 250);
  endtask

  initial begin
    #(4 * 190000);
    nerr++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b1 && dut_oe === 1'b0 && sclk === 1'b1 && valid === 1'b0,
        "R1 reset state", {busy, dut_oe, sclk, valid}, 4'b1010);
    repeat (300) @(negedge clk);
    pulse_start();
    @(negedge busy);
    @(negedge clk);
    chk(falls == 13, "R1 reset burst edges", falls, 13);
    chk(vcount == 0, "R1 no valid in burst", vcount, 0);
    chk(oe_cnt == 0, "R2 start ignored in burst", oe_cnt, 0);
    chk(s_in == 1'b1 && sclk === 1'b1, "R1 expander listening", {s_in, sclk}, 2'b11);

    for (int i = 0; i < NV; i++) read_word(VEC[i]);

    pins = 12'h5A3; falls = 0; vcount = 0; oe_cnt = 0;
    pulse_start();
    repeat (700) @(negedge clk);
    pulse_start();
    @(posedge valid);
    repeat (400) @(negedge clk);
    chk(falls == 13, "R2 start ignored mid read", falls, 13);
    chk(vcount == 1, "R2 single result", vcount, 1);
    chk(busy === 1'b0, "R2 idle after ignored start", busy, 0);
    chk(data === 12'h5A3, "R6 word after ignored start", data, 12'h5A3);

    chk(coll == 0, "R4 no contention", coll, 0);
    chk(oe_low_fall == 0, "R4 released at fall", oe_low_fall, 0);

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule